// File: doc/BRIEF.md
# Posted/Non-posted Request Issue Unit

This block is one request channel for a serial packet interconnect. A host loads a source address, a destination address, a byte count, a priority and a transaction kind, then pulses a start input. The channel cuts the transfer into request packets of at most `MAX_PKT` bytes. Before each packet it asks a transmit-slot allocator for credit at the programmed priority. Once a grant arrives, it hands the packet descriptor to the physical-layer queue.

The busy flag means only that the channel cannot take a new start yet. Its meaning depends on the transaction kind. A posted write releases the channel as soon as its last packet is queued. Non-posted writes, reads and doorbells keep the channel busy until every response strobe has arrived or the response timer runs out.

When credit is still refused after a bounded number of attempts, the transfer stops with a no-credit code. The working address and count registers then describe exactly the part not yet sent, so software can feed them back in to resume the transfer.

Top module: `req_issue_unit`

## Requirements
- R1: A start accepted while idle raises `busy_o` one cycle later and clears `cc_o` to 0 at the same moment. `busy_o` never rises without a start.
- R2: Each packet carries min(remaining, `MAX_PKT`) bytes. Packets go out in address order, with source and destination advancing by the length of each packet. When a transfer completes, the working count is 0 and the working addresses point past the last byte.
- R3: `pkt_valid_o` is high only in the cycle after a cycle where `cred_req_o` and `cred_gnt_i` were both high. `cred_prio_o` and `pkt_prio_o` carry the programmed priority.
- R4: For a posted write (kind 0), `busy_o` is low in the cycle after the last packet is issued, and `cc_o` is 0.
- R5: For kinds 1 (non-posted write), 2 (read) and 3 (doorbell), `busy_o` stays high until one `rsp_ack_i` strobe has been seen per issued packet. When all strobes have arrived, the transfer ends with `cc_o` = 0. A strobe received while no response is outstanding has no effect.
- R6: `RETRY_LIMIT` consecutive denied credit requests for one packet end the transfer with `cc_o` = 7. One denial fewer followed by a grant still completes normally.
- R7: After a code-7 stop, the working count holds the unsent bytes and the working addresses are advanced past the bytes already sent. Restarting with those values sends only the remainder.
- R8: If `RSP_TIMEOUT` cycles pass with a response outstanding and no packet or strobe in between, the transfer ends with `cc_o` = 1.
- R9: A start while `busy_o` is high is ignored. It neither reloads registers nor adds packets, and it sets the sticky `start_err_o` flag, which only reset clears.
- R10: A doorbell issues exactly one packet of length 0 with kind 3 and leaves the working count and addresses unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse |
| cfg_src_i | input | AW | Source address to load |
| cfg_dst_i | input | AW | Destination address to load |
| cfg_bytes_i | input | CW | Byte count to load |
| cfg_prio_i | input | 2 | Request priority |
| cfg_kind_i | input | 2 | 0 posted write, 1 non-posted write, 2 read, 3 doorbell |
| busy_o | output | 1 | Channel cannot accept a start |
| cc_o | output | 3 | Completion code: 0 ok, 1 response timeout, 7 no credit |
| start_err_o | output | 1 | Sticky start-while-busy flag |
| cur_src_o | output | AW | Working source address |
| cur_dst_o | output | AW | Working destination address |
| cur_bytes_o | output | CW | Working remaining byte count |
| cred_req_o | output | 1 | Credit request, one attempt per cycle |
| cred_prio_o | output | 2 | Priority of the credit request |
| cred_gnt_i | input | 1 | Credit granted in this cycle |
| pkt_valid_o | output | 1 | Packet descriptor valid |
| pkt_src_o | output | AW | Packet source address |
| pkt_dst_o | output | AW | Packet destination address |
| pkt_len_o | output | LW | Packet length in bytes |
| pkt_prio_o | output | 2 | Packet priority |
| pkt_kind_o | output | 2 | Packet transaction kind |
| rsp_ack_i | input | 1 | One response received |

## Verification
A wrong segment length or address step appears in the very next descriptor on the packet port, and the scoreboard compares every descriptor. A broken outstanding-response count shows up within a few cycles of the last strobe: busy either drops early or hangs until the timeout produces code 1. A faulty attempt counter shifts the code-7 stop by one cycle, and the tests with exactly one attempt below the limit and exactly at the limit expose that. Errors in the resume registers surface when the transfer restarts and its descriptors are checked.

// File: rtl/riu_pkg.sv
package riu_pkg;
   typedef enum logic [1:0] {
      TT_POST_WR = 2'd0,
      TT_NP_WR   = 2'd1,
      TT_READ    = 2'd2,
      TT_DBELL   = 2'd3
   } xact_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_CRED,
      ST_ISSUE,
      ST_DRAIN
   } chan_st_e;

   localparam logic [2:0] CC_OK        = 3'd0;
   localparam logic [2:0] CC_RSP_TMO   = 3'd1;
   localparam logic [2:0] CC_NO_CREDIT = 3'd7;
endpackage

// File: rtl/riu_seg_calc.sv
module riu_seg_calc #(
   parameter int CW      = 16,
   parameter int MAX_PKT = 256,
   parameter int LW      = $clog2(MAX_PKT) + 1
) (
   input  logic [CW-1:0] remain_i,
   input  logic          bell_i,
   output logic [LW-1:0] seg_len_o,
   output logic          last_o
);
   localparam int SH = $clog2(MAX_PKT);

   if ((1 << SH) != MAX_PKT) begin : g_bad_max
      $error("riu_seg_calc: MAX_PKT must be a power of two");
   end
   if (LW != SH + 1) begin : g_bad_lw
      $error("riu_seg_calc: LW must equal log2(MAX_PKT)+1");
   end

   logic over;

   if (CW > SH) begin : g_wide
      // count may exceed one packet
      assign over = remain_i > CW'(MAX_PKT);
      always_comb begin
         if (bell_i)    seg_len_o = '0;
         else if (over) seg_len_o = LW'(MAX_PKT);
         else           seg_len_o = remain_i[LW-1:0];
      end
   end else begin : g_narrow
      // count always fits in one packet
      assign over = 1'b0;
      always_comb seg_len_o = bell_i ? '0 : LW'(remain_i);
   end

   assign last_o = bell_i | ~over;
endmodule

// File: rtl/riu_credit_try.sv
module riu_credit_try #(
   parameter int RETRY_LIMIT = 16,
   parameter int RW          = $clog2(RETRY_LIMIT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic try_i,
   input  logic gnt_i,
   output logic give_up_o
);
   if (RETRY_LIMIT < 1) begin : g_bad_lim
      $error("riu_credit_try: RETRY_LIMIT must be at least 1");
   end

   logic [RW-1:0] att_q;
   logic          deny;

   assign deny      = try_i & ~gnt_i;
   assign give_up_o = deny && (att_q == RW'(RETRY_LIMIT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          att_q <= '0;
      else if (clr_i | gnt_i | give_up_o) att_q <= '0;
      else if (deny)                       att_q <= att_q + RW'(1);
   end

   // R6
   att_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      att_q < RW'(RETRY_LIMIT));
endmodule

// File: rtl/riu_rsp_track.sv
module riu_rsp_track #(
   parameter int OW  = 9,
   parameter int TMO = 64,
   parameter int TW  = $clog2(TMO)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic sent_i,
   input  logic ack_i,
   output logic pending_o,
   output logic timeout_o
);
   if (TMO < 2) begin : g_bad_tmo
      $error("riu_rsp_track: TMO must be at least 2");
   end

   logic [OW-1:0] out_q;
   logic [TW-1:0] tmr_q;
   logic          ack_ok;
   logic          quiet;

   assign pending_o = out_q != '0;
   assign ack_ok    = ack_i & pending_o;
   assign quiet     = pending_o & ~ack_i & ~sent_i;
   assign timeout_o = quiet && (tmr_q == TW'(TMO - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 out_q <= '0;
      else if (clr_i | timeout_o) out_q <= '0;
      else if (sent_i && !ack_ok) out_q <= out_q + OW'(1);
      else if (!sent_i && ack_ok) out_q <= out_q - OW'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           tmr_q <= '0;
      else if (clr_i | timeout_o | ~quiet)  tmr_q <= '0;
      else                                  tmr_q <= tmr_q + TW'(1);
   end

   // R5
   drain_by_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(pending_o) && !$past(clr_i) && !$past(timeout_o)) |-> $past(ack_i));
endmodule

// File: rtl/req_issue_unit.sv
module req_issue_unit
   import riu_pkg::*;
#(
   parameter int AW          = 32,
   parameter int CW          = 16,
   parameter int MAX_PKT     = 256,
   parameter int RETRY_LIMIT = 16,
   parameter int RSP_TIMEOUT = 64,
   parameter int LW          = $clog2(MAX_PKT) + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [AW-1:0] cfg_src_i,
   input  logic [AW-1:0] cfg_dst_i,
   input  logic [CW-1:0] cfg_bytes_i,
   input  logic [1:0]    cfg_prio_i,
   input  logic [1:0]    cfg_kind_i,
   output logic          busy_o,
   output logic [2:0]    cc_o,
   output logic          start_err_o,
   output logic [AW-1:0] cur_src_o,
   output logic [AW-1:0] cur_dst_o,
   output logic [CW-1:0] cur_bytes_o,
   output logic          cred_req_o,
   output logic [1:0]    cred_prio_o,
   input  logic          cred_gnt_i,
   output logic          pkt_valid_o,
   output logic [AW-1:0] pkt_src_o,
   output logic [AW-1:0] pkt_dst_o,
   output logic [LW-1:0] pkt_len_o,
   output logic [1:0]    pkt_prio_o,
   output logic [1:0]    pkt_kind_o,
   input  logic          rsp_ack_i
);
   localparam int SH = $clog2(MAX_PKT);
   localparam int OW = (CW > SH) ? (CW - SH + 1) : 2;

   if (AW < LW) begin : g_bad_aw
      $error("req_issue_unit: AW must hold a packet length");
   end

   chan_st_e      st_q, st_d;
   xact_e         kind_q;
   logic [1:0]    prio_q;
   logic [AW-1:0] src_q, dst_q;
   logic [CW-1:0] bytes_q;
   logic [2:0]    cc_q, cc_d;
   logic          err_q;

   logic [LW-1:0] seg_len;
   logic          seg_last;
   logic          give_up;
   logic          pend, tmo;
   logic          posted, bell;
   logic          start_ok, finish;

   assign posted   = kind_q == TT_POST_WR;
   assign bell     = kind_q == TT_DBELL;
   assign busy_o   = st_q != ST_IDLE;
   assign start_ok = start_i & ~busy_o;

   riu_seg_calc #(.CW(CW), .MAX_PKT(MAX_PKT), .LW(LW)) u_seg (
      .remain_i (bytes_q),
      .bell_i   (bell),
      .seg_len_o(seg_len),
      .last_o   (seg_last)
   );

   riu_credit_try #(.RETRY_LIMIT(RETRY_LIMIT)) u_try (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (start_ok),
      .try_i    (cred_req_o),
      .gnt_i    (cred_gnt_i),
      .give_up_o(give_up)
   );

   riu_rsp_track #(.OW(OW), .TMO(RSP_TIMEOUT)) u_trk (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (start_ok | finish),
      .sent_i   (pkt_valid_o & ~posted),
      .ack_i    (rsp_ack_i),
      .pending_o(pend),
      .timeout_o(tmo)
   );

   always_comb begin
      st_d = st_q;
      cc_d = cc_q;
      unique case (st_q)
         ST_IDLE: if (start_i) st_d = ST_CRED;
         ST_CRED: begin
            if (tmo) begin
               st_d = ST_IDLE;
               cc_d = CC_RSP_TMO;
            end else if (cred_gnt_i) begin
               st_d = ST_ISSUE;
            end else if (give_up) begin
               st_d = ST_IDLE;
               cc_d = CC_NO_CREDIT;
            end
         end
         ST_ISSUE: begin
            if (!seg_last)   st_d = ST_CRED;
            else if (posted) st_d = ST_IDLE;
            else             st_d = ST_DRAIN;
         end
         ST_DRAIN: begin
            if (tmo) begin
               st_d = ST_IDLE;
               cc_d = CC_RSP_TMO;
            end else if (!pend) begin
               st_d = ST_IDLE;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   assign finish = busy_o && (st_d == ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         kind_q  <= TT_POST_WR;
         prio_q  <= '0;
         src_q   <= '0;
         dst_q   <= '0;
         bytes_q <= '0;
         cc_q    <= CC_OK;
         err_q   <= 1'b0;
      end else begin
         st_q <= st_d;
         if (start_i && busy_o) err_q <= 1'b1;
         if (start_ok) begin
            kind_q  <= xact_e'(cfg_kind_i);
            prio_q  <= cfg_prio_i;
            src_q   <= cfg_src_i;
            dst_q   <= cfg_dst_i;
            bytes_q <= cfg_bytes_i;
            cc_q    <= CC_OK;
         end else begin
            cc_q <= cc_d;
            if (st_q == ST_ISSUE) begin
               src_q   <= src_q + AW'(seg_len);
               dst_q   <= dst_q + AW'(seg_len);
               bytes_q <= bytes_q - CW'(seg_len);
            end
         end
      end
   end

   assign cc_o        = cc_q;
   assign start_err_o = err_q;
   assign cur_src_o   = src_q;
   assign cur_dst_o   = dst_q;
   assign cur_bytes_o = bytes_q;
   assign cred_req_o  = st_q == ST_CRED;
   assign cred_prio_o = prio_q;
   assign pkt_valid_o = st_q == ST_ISSUE;
   assign pkt_src_o   = src_q;
   assign pkt_dst_o   = dst_q;
   assign pkt_len_o   = seg_len;
   assign pkt_prio_o  = prio_q;
   assign pkt_kind_o  = kind_q;

   // R1
   launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(start_i));

   // R3
   grant_before_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_valid_o |-> $past(cred_req_o && cred_gnt_i));

   // R4
   posted_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_valid_o && posted && seg_last) |=> !busy_o);

   // R5
   np_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_DRAIN && pend && !tmo) |=> busy_o);

   // R6
   nocred_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy_o) && cc_o == CC_NO_CREDIT) |-> $past(cred_req_o && !cred_gnt_i));

   // R9
   busy_start_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && busy_o) |=> start_err_o);
endmodule

// File: tb/tb_req_issue_unit.sv
`timescale 1ns/1ps
module tb_req_issue_unit;
   localparam int AW = 32;
   localparam int CW = 16;
   localparam int MAX_PKT = 256;
   localparam int RETRY_LIMIT = 16;
   localparam int RSP_TIMEOUT = 64;
   localparam int LW = $clog2(MAX_PKT) + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic [AW-1:0] cfg_src_i = '0, cfg_dst_i = '0;
   logic [CW-1:0] cfg_bytes_i = '0;
   logic [1:0] cfg_prio_i = '0, cfg_kind_i = '0;
   logic busy_o, start_err_o, cred_req_o, pkt_valid_o;
   logic [2:0] cc_o;
   logic [AW-1:0] cur_src_o, cur_dst_o, pkt_src_o, pkt_dst_o;
   logic [CW-1:0] cur_bytes_o;
   logic [1:0] cred_prio_o, pkt_prio_o, pkt_kind_o;
   logic [LW-1:0] pkt_len_o;
   logic cred_gnt_i = 1'b0;
   logic rsp_ack_i = 1'b0;

   always #2.5 clk = ~clk;

   req_issue_unit #(.AW(AW), .CW(CW), .MAX_PKT(MAX_PKT), .RETRY_LIMIT(RETRY_LIMIT),
                    .RSP_TIMEOUT(RSP_TIMEOUT), .LW(LW)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .cfg_src_i(cfg_src_i),
      .cfg_dst_i(cfg_dst_i), .cfg_bytes_i(cfg_bytes_i), .cfg_prio_i(cfg_prio_i),
      .cfg_kind_i(cfg_kind_i), .busy_o(busy_o), .cc_o(cc_o), .start_err_o(start_err_o),
      .cur_src_o(cur_src_o), .cur_dst_o(cur_dst_o), .cur_bytes_o(cur_bytes_o),
      .cred_req_o(cred_req_o), .cred_prio_o(cred_prio_o), .cred_gnt_i(cred_gnt_i),
      .pkt_valid_o(pkt_valid_o), .pkt_src_o(pkt_src_o), .pkt_dst_o(pkt_dst_o),
      .pkt_len_o(pkt_len_o), .pkt_prio_o(pkt_prio_o), .pkt_kind_o(pkt_kind_o),
      .rsp_ack_i(rsp_ack_i));

   typedef struct packed {
      logic [AW-1:0] src;
      logic [AW-1:0] dst;
      logic [LW-1:0] len;
      logic [1:0]    prio;
      logic [1:0]    kind;
   } pkt_t;

   pkt_t exp_q[$];
   int total = 0;
   int bad = 0;
   int pkts_seen = 0;
   int deny_left = 0;
   int grants_left = -1;

   task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                      input logic [127:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   // monitor: pops the scoreboard on each issued packet
   always @(negedge clk) begin : mon
      pkt_t got;
      pkt_t want;
      if (rst_n && pkt_valid_o) begin
         got.src = pkt_src_o; got.dst = pkt_dst_o; got.len = pkt_len_o;
         got.prio = pkt_prio_o; got.kind = pkt_kind_o;
         pkts_seen++;
         if (exp_q.size() == 0) begin
            chk(1'b0, "R9 unexpected packet", got, '0);
         end else begin
            want = exp_q.pop_front();
            chk(got == want, "R2 R3 packet descriptor", got, want);
         end
      end
   end

   // credit allocator model
   always @(negedge clk) begin
      if (cred_req_o) begin
         if (deny_left > 0) begin
            cred_gnt_i = 1'b0;
            deny_left--;
         end else if (grants_left == 0) begin
            cred_gnt_i = 1'b0;
         end else begin
            cred_gnt_i = 1'b1;
            if (grants_left > 0) grants_left--;
         end
      end else begin
         cred_gnt_i = 1'b0;
      end
   end

   task automatic tick;
      @(negedge clk);
      #1;
   endtask

   task automatic ack_pulse;
      rsp_ack_i = 1'b1;
      tick();
      rsp_ack_i = 1'b0;
   endtask

   task automatic wait_idle(input int lim);
      for (int i = 0; i < lim && busy_o; i++) tick();
   endtask

   task automatic wait_pkts(input int n);
      for (int i = 0; i < 2000 && pkts_seen < n; i++) tick();
   endtask

   // driver: pushes expected packets, then pulses start
   task automatic launch(input logic [AW-1:0] s, input logic [AW-1:0] d, input int n,
                         input logic [1:0] p, input logic [1:0] k, input int npush);
      int rem;
      logic [AW-1:0] cs, cd;
      rem = n; cs = s; cd = d;
      for (int i = 0; i < npush; i++) begin
         pkt_t e;
         int len;
         len = (k == 2'd3) ? 0 : ((rem > MAX_PKT) ? MAX_PKT : rem);
         e.src = cs; e.dst = cd; e.len = LW'(len); e.prio = p; e.kind = k;
         exp_q.push_back(e);
         cs = cs + AW'(len); cd = cd + AW'(len); rem = rem - len;
      end
      cfg_src_i = s; cfg_dst_i = d; cfg_bytes_i = CW'(n);
      cfg_prio_i = p; cfg_kind_i = k; start_i = 1'b1;
      tick();
      start_i = 1'b0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      int base;
      repeat (3) tick();
      chk(busy_o == 1'b0, "R1 reset busy", busy_o, 0);
      chk(cc_o == 3'd0, "R1 reset code", cc_o, 0);
      chk(start_err_o == 1'b0, "R9 reset flag", start_err_o, 0);
      chk(pkt_valid_o == 1'b0 && cred_req_o == 1'b0, "R3 reset idle", pkt_valid_o, 0);
      rst_n = 1'b1;
      tick();

      // posted write, three packets
      base = pkts_seen;
      launch(32'h1000, 32'h8000, 600, 2'd0, 2'd0, 3);
      chk(busy_o == 1'b1, "R1 busy after start", busy_o, 1);
      chk(cc_o == 3'd0, "R1 code after start", cc_o, 0);
      wait_pkts(base + 3);
      chk(busy_o == 1'b1, "R4 busy during last issue", busy_o, 1);
      tick();
      chk(busy_o == 1'b0, "R4 busy clears after last packet", busy_o, 0);
      chk(cc_o == 3'd0, "R4 code", cc_o, 0);
      chk(cur_bytes_o == 0, "R2 count done", cur_bytes_o, 0);
      chk(cur_src_o == 32'h1258, "R2 src advanced", cur_src_o, 32'h1258);

      // non-posted write, two packets, priority 2, plus a start while busy
      base = pkts_seen;
      launch(32'h3000, 32'h9000, 300, 2'd2, 2'd1, 2);
      chk(cred_req_o == 1'b1 && cred_prio_o == 2'd2, "R3 credit priority", cred_prio_o, 2);
      wait_pkts(base + 1);
      cfg_src_i = 32'hdead; cfg_bytes_i = 16'd50; cfg_kind_i = 2'd0; start_i = 1'b1;
      tick();
      start_i = 1'b0;
      chk(start_err_o == 1'b1, "R9 sticky flag", start_err_o, 1);
      wait_pkts(base + 2);
      repeat (5) tick();
      chk(busy_o == 1'b1, "R5 busy while responses owed", busy_o, 1);
      ack_pulse();
      repeat (3) tick();
      chk(busy_o == 1'b1, "R5 busy with one response owed", busy_o, 1);
      ack_pulse();
      repeat (3) tick();
      chk(busy_o == 1'b0, "R5 busy clears after responses", busy_o, 0);
      chk(cc_o == 3'd0, "R5 code", cc_o, 0);
      chk(cur_bytes_o == 0 && cur_src_o == 32'h312c, "R9 ignored start left registers",
          cur_src_o, 32'h312c);
      chk(start_err_o == 1'b1, "R9 flag stays", start_err_o, 1);

      // one denial below the limit
      deny_left = RETRY_LIMIT - 1;
      launch(32'h2000, 32'h3000, 100, 2'd1, 2'd0, 1);
      wait_idle(300);
      chk(cc_o == 3'd0, "R6 limit-1 denials succeed", cc_o, 0);
      chk(cur_bytes_o == 0, "R6 sent", cur_bytes_o, 0);

      // exactly the limit
      deny_left = RETRY_LIMIT;
      launch(32'h2000, 32'h3000, 100, 2'd1, 2'd0, 0);
      wait_idle(300);
      chk(cc_o == 3'd7, "R6 limit denials give code 7", cc_o, 7);
      chk(cur_bytes_o == 100 && cur_src_o == 32'h2000, "R7 nothing sent", cur_bytes_o, 100);

      // stop mid transfer after two packets
      grants_left = 2;
      launch(32'h10000, 32'h20000, 1000, 2'd0, 2'd0, 2);
      chk(cc_o == 3'd0, "R1 code cleared by start", cc_o, 0);
      wait_idle(500);
      chk(cc_o == 3'd7, "R7 code 7", cc_o, 7);
      chk(cur_bytes_o == 488, "R7 remaining count", cur_bytes_o, 488);
      chk(cur_src_o == 32'h10200 && cur_dst_o == 32'h20200, "R7 advanced addresses",
          cur_src_o, 32'h10200);

      // resume from working registers
      grants_left = -1;
      launch(cur_src_o, cur_dst_o, int'(cur_bytes_o), 2'd0, 2'd0, 2);
      wait_idle(500);
      chk(cc_o == 3'd0 && cur_bytes_o == 0, "R7 resume completes", cur_bytes_o, 0);
      chk(cur_src_o == 32'h103e8, "R7 resume end address", cur_src_o, 32'h103e8);

      // read with no response
      launch(32'h4000, 32'h5000, 100, 2'd0, 2'd2, 1);
      repeat (30) tick();
      chk(busy_o == 1'b1, "R8 busy before timeout", busy_o, 1);
      wait_idle(500);
      chk(cc_o == 3'd1, "R8 timeout code", cc_o, 1);

      // stray strobe while idle, then doorbell
      ack_pulse();
      ack_pulse();
      base = pkts_seen;
      launch(32'h6000, 32'h7000, 500, 2'd3, 2'd3, 1);
      wait_pkts(base + 1);
      repeat (10) tick();
      chk(busy_o == 1'b1, "R5 R10 stray strobes ignored", busy_o, 1);
      ack_pulse();
      repeat (3) tick();
      chk(busy_o == 1'b0 && cc_o == 3'd0, "R10 doorbell completes", cc_o, 0);
      chk(cur_bytes_o == 500 && cur_src_o == 32'h6000, "R10 registers untouched",
          cur_bytes_o, 500);
      chk(pkts_seen == base + 1, "R10 single packet", pkts_seen, base + 1);

      chk(exp_q.size() == 0, "R2 all expected packets seen", exp_q.size(), 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule